// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Target

This block is the device-side logic of a two-wire in-system programming port. A host drives a serial clock and a shared data line. The block shifts in 6-bit commands and decodes them. It then takes in or sends a 16-clock data frame when the command has one. The block also keeps the program address counter and raises single-cycle requests toward a memory and erase/program controller.

The serial clock and the data line pass through a synchroniser into a fast system clock. Edge detection then drives a small frame sequencer. The sequencer's control half sends strobes to a datapath half. The datapath holds the address counter, the load latch, the read shift register and an error counter.

The address counter is split in two. User space wraps within the lower half of the address range. Configuration space is entered by a dedicated command and wraps within the upper half. The block stays in configuration space until the mode-active input drops. Commands that arrive while the external controller reports busy do nothing except increment the error counter.

Top module: `spv_target`

## Requirements
- R1: After reset, and whenever mode-active is low, the address is 0, the data output enable is low, no request is raised and the error count is 0.
- R2: A command is 6 bits, sampled on falling serial-clock edges, least significant bit first. For commands marked x, the top two bits are ignored. The increment command (low bits 0110) adds one to the address.
- R3: In user space (address top bit 0), incrementing from the last user address wraps to 0.
- R4: The load-configuration command (low bits 0000) sets the address to the configuration base, which is the top address bit set and all others clear (0x2000 at the default width). Increments then wrap back to that base, and the top bit stays set until mode-active drops.
- R5: The load-program command (low bits 0010) takes a 16-falling-edge frame. The payload is the 14 bits sampled on falling edges 2 to 15, least significant bit first. A following begin-erase-program command (exactly 001000) raises a one-cycle write request carrying that payload, the current address, the data-space flag low and the erase flag high.
- R6: A begin-program-only command (exactly 011000) raises the same write request with the erase flag low.
- R7: A begin command that has no load before it raises no request. Each begin command uses up the load it follows.
- R8: For a read-program command (low bits 0100), the output enable rises on the 2nd rising edge of the frame. The payload is then driven least significant bit first, one bit per rising edge through the 15th. The output enable is low after the 1st and after the 16th rising edge.
- R9: The load-data-memory command (low bits 0011) keeps only the low 8 payload bits and sets the data-space flag on the write. The read-data-memory command (low bits 0101) returns the low 8 bits of the memory word with the upper 6 bits zero.
- R10: With program protection on, reads of user-space program words return zero, while reads of configuration-space words do not change. With data protection on, data-memory reads return zero.
- R11: While busy is high, a completed command has no effect and adds one to the error count, which saturates at its maximum. If that command carries a frame, the frame is still taken in, but its payload is discarded and the output enable stays low.
- R12: Dropping mode-active clears the address, including its top bit, and any pending load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rstN | input | 1 | Active-low synchronous reset |
| modeActive | input | 1 | High while program/verify mode is entered |
| serClk | input | 1 | Serial clock from the host |
| serDin | input | 1 | Serial data from the host |
| serDout | output | 1 | Serial data toward the host, valid while serOe is high |
| serOe | output | 1 | Data-line output enable |
| busy | input | 1 | Erase/program timer of the controller is running |
| protProg | input | 1 | Program memory protection |
| protData | input | 1 | Data memory protection |
| memAddr | output | ADDR_W | Current program address |
| memIsData | output | 1 | Request targets data memory |
| memRdReq | output | 1 | One-cycle read request; data expected next cycle |
| memRdData | input | PAY_W | Read word from the memory |
| memWrReq | output | 1 | One-cycle write request |
| memWrData | output | PAY_W | Word to be written |
| progErase | output | 1 | Write request includes a word erase |
| errCount | output | ERR_W | Count of commands rejected while busy |

## Verification
The hardest behaviour to reach from the ports is the wrap at both ends of the address space. At full width, it would take thousands of serial increments to get there. The bench builds the block with an 8-bit address, so it can sweep every user address and every configuration address through its wrap, checking each value arithmetically. A busy window is held open across whole command and frame sequences. This shows that rejected frames are still taken in, without losing framing for the command that follows.

// File: rtl/spv_pkg.sv
package spv_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_LDCFG, OP_LDPROG, OP_LDDATA, OP_RDPROG, OP_RDDATA,
    OP_INC, OP_BEGEP, OP_BEGPO, OP_BULK1, OP_BULK2
  } opT;

  typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_READ, ST_SKIP} stateT;

  typedef struct packed {
    logic addrCfg;
    logic addrInc;
    logic loadShift;
    logic loadCommit;
    logic loadIsData;
    logic rdCapture;
    logic rdIsData;
    logic outShift;
    logic errInc;
  } strobeT;

  function automatic opT decodeCmd(input logic [5:0] c);
    casez (c)
      6'b??0000: return OP_LDCFG;
      6'b??0010: return OP_LDPROG;
      6'b??0011: return OP_LDDATA;
      6'b??0100: return OP_RDPROG;
      6'b??0101: return OP_RDDATA;
      6'b??0110: return OP_INC;
      6'b001000: return OP_BEGEP;
      6'b011000: return OP_BEGPO;
      6'b000001: return OP_BULK1;
      6'b000111: return OP_BULK2;
      default:   return OP_NONE;
    endcase
  endfunction

  function automatic logic hasFrame(input opT op);
    return (op == OP_LDCFG) || (op == OP_LDPROG) || (op == OP_LDDATA) ||
           (op == OP_RDPROG) || (op == OP_RDDATA);
  endfunction

endpackage

// File: rtl/spv_control.sv
module spv_control
  import spv_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeActive,
  input  logic   serClk,
  input  logic   serDin,
  input  logic   busy,
  output strobeT stb,
  output logic   serBit,
  output logic   serOe,
  output logic   memRdReq,
  output logic   memWrReq,
  output logic   memIsData,
  output logic   progErase
);

  localparam int FRAME_LAST = 15;
  localparam int CMD_LAST   = 5;

  logic [2:0] clkSync;
  logic [1:0] dinSync;
  logic       riseEdge, fallEdge;

  stateT      stateQ;
  logic [4:0] bitCnt;
  logic [5:0] cmdShift, cmdNext;
  logic       loadedQ, loadedDataQ, frameDataQ;
  logic       oeQ, rdReqQ, rdCapQ, wrReqQ, memIsDataQ, eraseQ;
  logic       cmdDone, accept;
  opT         opNow;

  assign riseEdge = clkSync[1] & ~clkSync[2];
  assign fallEdge = ~clkSync[1] & clkSync[2];
  assign serBit   = dinSync[1];
  assign cmdNext  = {serBit, cmdShift[5:1]};
  assign opNow    = decodeCmd(cmdNext);
  assign cmdDone  = fallEdge && (stateQ == ST_CMD) && (bitCnt == 5'(CMD_LAST));
  assign accept   = cmdDone && !busy;

  always_comb begin
    stb            = '0;
    stb.addrCfg    = accept && (opNow == OP_LDCFG);
    stb.addrInc    = accept && (opNow == OP_INC);
    stb.loadShift  = fallEdge && (stateQ == ST_LOAD) &&
                     (bitCnt >= 5'd1) && (bitCnt <= 5'd14);
    stb.loadCommit = fallEdge && (stateQ == ST_LOAD) &&
                     (bitCnt == 5'(FRAME_LAST));
    stb.loadIsData = frameDataQ;
    stb.rdCapture  = rdCapQ;
    stb.rdIsData   = memIsDataQ;
    stb.outShift   = riseEdge && (stateQ == ST_READ) &&
                     (bitCnt >= 5'd2) && (bitCnt <= 5'd14);
    stb.errInc     = cmdDone && busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync     <= '0;
      dinSync     <= '0;
      stateQ      <= ST_CMD;
      bitCnt      <= '0;
      cmdShift    <= '0;
      loadedQ     <= 1'b0;
      loadedDataQ <= 1'b0;
      frameDataQ  <= 1'b0;
      oeQ         <= 1'b0;
      rdReqQ      <= 1'b0;
      rdCapQ      <= 1'b0;
      wrReqQ      <= 1'b0;
      memIsDataQ  <= 1'b0;
      eraseQ      <= 1'b0;
    end else begin
      clkSync <= {clkSync[1:0], serClk};
      dinSync <= {dinSync[0], serDin};
      rdReqQ  <= 1'b0;
      wrReqQ  <= 1'b0;
      rdCapQ  <= rdReqQ;
      if (!modeActive) begin
        stateQ   <= ST_CMD;
        bitCnt   <= '0;
        cmdShift <= '0;
        loadedQ  <= 1'b0;
        oeQ      <= 1'b0;
        rdCapQ   <= 1'b0;
      end else begin
        case (stateQ)
          ST_CMD: if (fallEdge) begin
            cmdShift <= cmdNext;
            if (bitCnt == 5'(CMD_LAST)) begin
              bitCnt <= '0;
              if (busy) begin
                if (hasFrame(opNow)) stateQ <= ST_SKIP;
              end else begin
                case (opNow)
                  OP_LDCFG, OP_LDPROG: begin
                    stateQ     <= ST_LOAD;
                    frameDataQ <= 1'b0;
                  end
                  OP_LDDATA: begin
                    stateQ     <= ST_LOAD;
                    frameDataQ <= 1'b1;
                  end
                  OP_RDPROG, OP_RDDATA: begin
                    stateQ     <= ST_READ;
                    rdReqQ     <= 1'b1;
                    memIsDataQ <= (opNow == OP_RDDATA);
                  end
                  OP_BEGEP, OP_BEGPO: if (loadedQ) begin
                    wrReqQ     <= 1'b1;
                    memIsDataQ <= loadedDataQ;
                    eraseQ     <= (opNow == OP_BEGEP);
                    loadedQ    <= 1'b0;
                  end
                  default: ;
                endcase
              end
            end else begin
              bitCnt <= bitCnt + 5'd1;
            end
          end
          ST_LOAD, ST_SKIP: if (fallEdge) begin
            if (bitCnt == 5'(FRAME_LAST)) begin
              bitCnt <= '0;
              stateQ <= ST_CMD;
              if (stateQ == ST_LOAD) begin
                loadedQ     <= 1'b1;
                loadedDataQ <= frameDataQ;
              end
            end else begin
              bitCnt <= bitCnt + 5'd1;
            end
          end
          ST_READ: begin
            if (riseEdge) begin
              bitCnt <= bitCnt + 5'd1;
              if (bitCnt == 5'd1) oeQ <= 1'b1;
              else if (bitCnt == 5'(FRAME_LAST)) oeQ <= 1'b0;
            end else if (fallEdge && bitCnt == 5'd16) begin
              bitCnt <= '0;
              stateQ <= ST_CMD;
            end
          end
          default: stateQ <= ST_CMD;
        endcase
      end
    end
  end

  assign serOe     = oeQ;
  assign memRdReq  = rdReqQ;
  assign memWrReq  = wrReqQ;
  assign memIsData = memIsDataQ;
  assign progErase = eraseQ;

endmodule

// File: rtl/spv_datapath.sv
module spv_datapath
  import spv_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAY_W  = 14,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeActive,
  input  strobeT            stb,
  input  logic              serBit,
  input  logic              protProg,
  input  logic              protData,
  input  logic [PAY_W-1:0]  memRdData,
  output logic [ADDR_W-1:0] addr,
  output logic [PAY_W-1:0]  wrData,
  output logic              outBit,
  output logic [ERR_W-1:0]  errCount
);

  localparam logic [ADDR_W-1:0] CFG_BASE  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [PAY_W-1:0]  DATA_MASK = {{(PAY_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

  logic [ADDR_W-1:0] addrQ;
  logic [PAY_W-1:0]  shiftIn, latchQ, rdShift, rdWord;
  logic [ERR_W-1:0]  errQ;
  logic              rdBlocked;

  assign rdBlocked = stb.rdIsData ? protData : (protProg & ~addrQ[ADDR_W-1]);
  assign rdWord    = rdBlocked ? '0 :
                     (stb.rdIsData ? (memRdData & DATA_MASK) : memRdData);

  always_ff @(posedge clk) begin
    if (!rstN || !modeActive) begin
      addrQ   <= '0;
      shiftIn <= '0;
      latchQ  <= '0;
      rdShift <= '0;
      errQ    <= '0;
    end else begin
      if (stb.addrCfg)
        addrQ <= CFG_BASE;
      else if (stb.addrInc)
        addrQ <= {addrQ[ADDR_W-1], addrQ[ADDR_W-2:0] + 1'b1};
      if (stb.loadShift)
        shiftIn <= {serBit, shiftIn[PAY_W-1:1]};
      if (stb.loadCommit)
        latchQ <= stb.loadIsData ? (shiftIn & DATA_MASK) : shiftIn;
      if (stb.rdCapture)
        rdShift <= rdWord;
      else if (stb.outShift)
        rdShift <= rdShift >> 1;
      if (stb.errInc && errQ != '1)
        errQ <= errQ + 1'b1;
    end
  end

  assign addr     = addrQ;
  assign wrData   = latchQ;
  assign outBit   = rdShift[0];
  assign errCount = errQ;

endmodule

// File: rtl/spv_target.sv
module spv_target
  import spv_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAY_W  = 14,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeActive,
  input  logic              serClk,
  input  logic              serDin,
  output logic              serDout,
  output logic              serOe,
  input  logic              busy,
  input  logic              protProg,
  input  logic              protData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memIsData,
  output logic              memRdReq,
  input  logic [PAY_W-1:0]  memRdData,
  output logic              memWrReq,
  output logic [PAY_W-1:0]  memWrData,
  output logic              progErase,
  output logic [ERR_W-1:0]  errCount
);

  strobeT stb;
  logic   serBit, outBit, oe;

  spv_control u_ctrl (
    .clk(clk), .rstN(rstN), .modeActive(modeActive),
    .serClk(serClk), .serDin(serDin), .busy(busy),
    .stb(stb), .serBit(serBit), .serOe(oe),
    .memRdReq(memRdReq), .memWrReq(memWrReq),
    .memIsData(memIsData), .progErase(progErase)
  );

  spv_datapath #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .modeActive(modeActive),
    .stb(stb), .serBit(serBit),
    .protProg(protProg), .protData(protData), .memRdData(memRdData),
    .addr(memAddr), .wrData(memWrData), .outBit(outBit), .errCount(errCount)
  );

  assign serOe   = oe;
  assign serDout = oe & outBit;

endmodule

// File: rtl/spv_target_chk.sv
module spv_target_chk #(
  parameter int ADDR_W = 14,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeActive,
  input logic              busy,
  input logic              serOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdReq,
  input logic              memWrReq,
  input logic [ERR_W-1:0]  errCount
);

  // R4
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memAddr[ADDR_W-1]) && $past(modeActive)) |-> memAddr[ADDR_W-1]);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |=> !memWrReq);

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrReq && memRdReq));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !memWrReq);

  // R11
  err_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeActive) |-> (errCount >= $past(errCount)));

  // R12
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> (memAddr == '0 && !serOe && !memWrReq));

endmodule

bind spv_target spv_target_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeActive(modeActive), .busy(busy),
  .serOe(serOe), .memAddr(memAddr), .memRdReq(memRdReq),
  .memWrReq(memWrReq), .errCount(errCount)
);

// File: tb/spv_target_bench.sv
module spv_target_bench;

  localparam int AW = 8;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeActive = 1'b0;
  logic serClk = 1'b0, serDin = 1'b0;
  logic busy = 1'b0, protProg = 1'b0, protData = 1'b0;
  logic serDout, serOe, memIsData, memRdReq, memWrReq, progErase;
  logic [AW-1:0] memAddr;
  logic [13:0] memRdData, memWrData;
  logic [7:0] errCount;

  logic [13:0] progMem [0:255];
  logic [13:0] dataMem [0:255];
  int          wrCount = 0;
  logic [AW-1:0] wrAddr;
  logic [13:0] wrData;
  logic        wrErase, wrIsData;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spv_target #(.ADDR_W(AW)) u_spv_target (
    .clk(clk), .rstN(rstN), .modeActive(modeActive),
    .serClk(serClk), .serDin(serDin), .serDout(serDout), .serOe(serOe),
    .busy(busy), .protProg(protProg), .protData(protData),
    .memAddr(memAddr), .memIsData(memIsData), .memRdReq(memRdReq),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrData(memWrData),
    .progErase(progErase), .errCount(errCount)
  );

  function automatic logic [13:0] progInit(input int i);
    return 14'((i * 'h35 + 7) & 'h3FFF);
  endfunction
  function automatic logic [13:0] dataInit(input int i);
    return 14'((i * 'h1B3 + 'h3C00) & 'h3FFF);
  endfunction
  function automatic logic [13:0] pat(input int a);
    return 14'((a * 'h0913 + 'h155) & 'h3FFF);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) begin
        progMem[i] <= progInit(i);
        dataMem[i] <= dataInit(i);
      end
      memRdData <= '0;
    end else begin
      if (memRdReq) memRdData <= memIsData ? dataMem[memAddr] : progMem[memAddr];
      if (memWrReq) begin
        wrCount  <= wrCount + 1;
        wrAddr   <= memAddr;
        wrData   <= memWrData;
        wrErase  <= progErase;
        wrIsData <= memIsData;
        if (memIsData) dataMem[memAddr] <= memWrData;
        else           progMem[memAddr] <= memWrData;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txBit(input logic b);
    @(negedge clk); serDin = b; serClk = 1'b1;
    repeat (H) @(negedge clk);
    serClk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) txBit(c[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic loadFrame(input logic [13:0] d);
    txBit(1'b0);
    for (int i = 0; i < 14; i++) txBit(d[i]);
    txBit(1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic readFrame(output logic [13:0] d, input bit expOe, output int oeErr);
    oeErr = 0;
    d = '0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk); serClk = 1'b1;
      repeat (H) @(negedge clk);
      if (i >= 2 && i <= 15) begin
        if (serOe !== expOe) oeErr++;
        d[i-2] = serDout;
      end else if (serOe !== 1'b0) oeErr++;
      serClk = 1'b0;
      repeat (H) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic modeCycle();
    @(negedge clk); modeActive = 1'b0;
    repeat (4) @(negedge clk);
    modeActive = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finishRun();
  end

  initial begin
    logic [13:0] v;
    int oeErr, prev;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", 32'(memAddr), 0);
    chk("R1 oe", 32'(serOe), 0);
    chk("R1 err", 32'(errCount), 0);
    chk("R1 wr", 32'(memWrReq), 0);
    modeActive = 1'b1;
    repeat (4) @(negedge clk);

    // R2 increments, with don't-care upper bits on the last one
    for (int k = 1; k <= 5; k++) begin
      sendCmd(6'b000110);
      chk("R2 inc", 32'(memAddr), 32'(k));
    end
    sendCmd(6'b110110);
    chk("R2 dontcare", 32'(memAddr), 6);

    // R3 user-space sweep through wrap
    for (int k = 7; k <= 130; k++) begin
      sendCmd(6'b000110);
      chk("R3 user wrap", 32'(memAddr), 32'(k & 'h7F));
    end

    // R4 configuration base and wrap
    sendCmd(6'b000000);
    loadFrame(14'h0);
    chk("R4 cfg base", 32'(memAddr), 'h80);
    for (int k = 1; k <= 129; k++) begin
      sendCmd(6'b000110);
      chk("R4 cfg wrap", 32'(memAddr), 32'('h80 | (k & 'h7F)));
    end

    // R12 mode exit clears address and pending load
    modeCycle();
    chk("R12 addr", 32'(memAddr), 0);
    sendCmd(6'b000010);
    loadFrame(14'h1111);
    modeCycle();
    prev = wrCount;
    sendCmd(6'b001000);
    chk("R12 load dropped", 32'(wrCount), 32'(prev));

    // R5/R6 program writes over eight addresses
    for (int a = 0; a < 8; a++) begin
      sendCmd(6'b000010);
      loadFrame(pat(a));
      prev = wrCount;
      sendCmd(a[0] ? 6'b011000 : 6'b001000);
      chk("R5 wr pulse", 32'(wrCount), 32'(prev + 1));
      chk("R5 wr data", 32'(wrData), 32'(pat(a)));
      chk("R5 wr addr", 32'(wrAddr), 32'(a));
      chk("R5 wr space", 32'(wrIsData), 0);
      chk("R6 erase flag", 32'(wrErase), 32'(!a[0]));
      sendCmd(6'b000110);
    end

    // R7 begin consumes the load; repeated begin ignored
    prev = wrCount;
    sendCmd(6'b001000);
    chk("R7 no load", 32'(wrCount), 32'(prev));

    // R8 read back
    modeCycle();
    for (int a = 0; a < 8; a++) begin
      sendCmd(6'b000100);
      readFrame(v, 1'b1, oeErr);
      chk("R8 read data", 32'(v), 32'(pat(a)));
      chk("R8 oe window", 32'(oeErr), 0);
      sendCmd(6'b000110);
    end

    // R9 data memory
    modeCycle();
    for (int k = 0; k < 3; k++) sendCmd(6'b000110);
    sendCmd(6'b000011);
    loadFrame(14'h3FA5);
    prev = wrCount;
    sendCmd(6'b001000);
    chk("R9 wr pulse", 32'(wrCount), 32'(prev + 1));
    chk("R9 wr data", 32'(wrData), 'hA5);
    chk("R9 wr space", 32'(wrIsData), 1);
    sendCmd(6'b000101);
    readFrame(v, 1'b1, oeErr);
    chk("R9 read back", 32'(v), 'hA5);
    sendCmd(6'b000110);
    sendCmd(6'b000101);
    readFrame(v, 1'b1, oeErr);
    chk("R9 read mask", 32'(v), 32'(dataInit(4) & 'hFF));

    // R10 protection
    modeCycle();
    protProg = 1'b1;
    sendCmd(6'b000100);
    readFrame(v, 1'b1, oeErr);
    chk("R10 user prot", 32'(v), 0);
    sendCmd(6'b000000);
    loadFrame(14'h0);
    sendCmd(6'b000100);
    readFrame(v, 1'b1, oeErr);
    chk("R10 cfg open", 32'(v), 32'(progInit('h80)));
    protData = 1'b1;
    sendCmd(6'b000101);
    readFrame(v, 1'b1, oeErr);
    chk("R10 data prot", 32'(v), 0);
    protProg = 1'b0;
    protData = 1'b0;

    // R11 busy rejection
    modeCycle();
    busy = 1'b1;
    sendCmd(6'b000110);
    chk("R11 addr held", 32'(memAddr), 0);
    chk("R11 err 1", 32'(errCount), 1);
    sendCmd(6'b000010);
    loadFrame(14'h2222);
    chk("R11 err 2", 32'(errCount), 2);
    sendCmd(6'b000100);
    readFrame(v, 1'b0, oeErr);
    chk("R11 no oe", 32'(oeErr), 0);
    chk("R11 err 3", 32'(errCount), 3);
    busy = 1'b0;
    prev = wrCount;
    sendCmd(6'b001000);
    chk("R11 load rejected", 32'(wrCount), 32'(prev));
    sendCmd(6'b000110);
    chk("R11 framing kept", 32'(memAddr), 1);

    finishRun();
  end

endmodule